// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor of the same width over several clock cycles. Each cycle it produces one quotient bit. The partial remainder is a signed register and is never restored during the run. In each step the remainder is doubled and the next dividend bit is brought in. The divisor is then subtracted if the previous remainder was non-negative, or added if it was negative. The sign of the result gives the quotient bit. After the last step, one correction cycle adds the divisor back when the remainder is still negative, so that the remainder comes out true.

A client presents operands together with a one-cycle `start` while the unit is idle. `busy` stays high for the whole computation. The quotient appears on `quot_lo` and the remainder on `rem_hi` in the cycle where `done` pulses, and both stay there until the next division completes. A zero divisor is not trapped. It runs through the same steps and raises `div_zero`. The result in that case is deterministic: the quotient is all ones and the remainder equals the dividend. Signed operands and quotient-overflow detection are not part of this block.

Top module: `seq_udiv_nr`

## Requirements
- R1: For a non-zero divisor, `quot_lo` equals floor(dividend / divisor) and `rem_hi` equals dividend mod divisor, both read as unsigned W-bit values, in the cycle where `done` is high.
- R2: `start` is accepted on a rising edge where the unit is idle. `done` then rises on the (W+1)-th rising edge after that edge: W step cycles and one correction cycle. `done` stays high for exactly one cycle.
- R3: `busy` is high from the edge that accepts `start` until the edge where `done` rises. `busy` is low whenever `done` is high.
- R4: `start` and operand changes while `busy` is high are ignored. The running division keeps its original operands, and no extra `done` pulse follows.
- R5: With a zero divisor, `div_zero` is 1, `quot_lo` is all ones and `rem_hi` equals the dividend, with the same latency as R2. With a non-zero divisor, `div_zero` is 0.
- R6: `quot_lo`, `rem_hi` and `div_zero` change only on the edge where `done` rises, and otherwise hold their values.
- R7: While reset is high and just after it, `busy`, `done`, `quot_lo`, `rem_hi` and `div_zero` are all 0.
- R8: After the final add-back correction, `rem_hi` is strictly less than a non-zero divisor. This holds even when the last partial remainder was negative.
- R9: The full unsigned range is covered. A dividend or divisor with the top bit set is treated as a large positive value. A dividend smaller than the divisor gives quotient 0 and the dividend as remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division (taken only when idle) |
| dividend | input | W | Unsigned dividend, sampled with `start` |
| divisor | input | W | Unsigned divisor, sampled with `start` |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quot_lo | output | W | Quotient |
| rem_hi | output | W | Remainder |
| div_zero | output | 1 | Divisor of the last completed division was zero |

## Verification
The bench builds two instances, one with W=32 and one with W=4. The 4-bit instance runs all 256 operand pairs, which covers every sign pattern of the partial remainder, every final add-back case and every zero-divisor case. The 32-bit instance takes directed corner operands and a pseudo-random stream. The corner operands include both top bits set, a dividend below the divisor, 26/5 and a zero divisor. The 32-bit instance also gets a second `start` injected in the middle of a run, and the latency is measured at W+1 for both widths.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_FIX  = 2'd2
  } nrdiv_state_t;
endpackage

// File: rtl/nrdiv_step.sv
// One non-restoring iteration: double the partial remainder, shift in the
// next dividend bit, then subtract or add the divisor according to the sign.
module nrdiv_step #(
  parameter int W = 32
) (
  input  logic [W:0]   prem_in,   // signed partial remainder, W+1 bits
  input  logic         next_bit,  // dividend bit shifted in
  input  logic [W-1:0] dvs,
  output logic [W:0]   prem_out,
  output logic         qbit
);
  localparam int XW = W + 2;

  logic [XW-1:0] doubled;
  logic [XW-1:0] dvs_ext;
  logic [XW-1:0] sum;

  always_comb begin
    doubled = {prem_in, next_bit};
    dvs_ext = {2'b00, dvs};
    if (prem_in[W]) sum = doubled + dvs_ext;
    else            sum = doubled - dvs_ext;
    // result lies in [-d, d) and fits in W+1 signed bits
    prem_out = sum[W:0];
    qbit     = ~sum[W];
  end
endmodule

// File: rtl/nrdiv_fsm.sv
module nrdiv_fsm
  import nrdiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step_en,
  output logic fix_en,
  output logic busy,
  output logic done
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  nrdiv_state_t state;
  logic [CW-1:0] cnt;

  assign load    = start && (state == ST_IDLE);
  assign step_en = (state == ST_STEP);
  assign fix_en  = (state == ST_FIX);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_STEP;
          cnt   <= '0;
        end
        ST_STEP: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIX;
        end
        ST_FIX: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: the correction cycle always follows a step cycle
  p_fix_after_step_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIX) |-> ($past(state) == ST_STEP));

  // R3: busy and done never overlap
  p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R4: a start during a running step does not restart or end the run
  p_start_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (step_en && start && (cnt != LAST)) |=> step_en);
endmodule

// File: rtl/nrdiv_core.sv
module nrdiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step_en,
  input  logic         fix_en,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot_lo,
  output logic [W-1:0] rem_hi,
  output logic         div_zero
);
  logic [W:0]   prem;
  logic [W-1:0] acc;
  logic [W-1:0] dvs;
  logic         zflag;

  logic [W:0]   prem_nxt;
  logic         qbit;
  logic [W:0]   prem_fix;

  nrdiv_step #(.W(W)) u_step (
    .prem_in  (prem),
    .next_bit (acc[W-1]),
    .dvs      (dvs),
    .prem_out (prem_nxt),
    .qbit     (qbit)
  );

  // single add-back when the last partial remainder is negative
  always_comb begin
    if (prem[W]) prem_fix = prem + {1'b0, dvs};
    else         prem_fix = prem;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prem     <= '0;
      acc      <= '0;
      dvs      <= '0;
      zflag    <= 1'b0;
      quot_lo  <= '0;
      rem_hi   <= '0;
      div_zero <= 1'b0;
    end else begin
      if (load) begin
        prem  <= '0;
        acc   <= dividend;
        dvs   <= divisor;
        zflag <= (divisor == '0);
      end else if (step_en) begin
        prem <= prem_nxt;
        acc  <= {acc[W-2:0], qbit};
      end
      if (fix_en) begin
        quot_lo  <= acc;
        rem_hi   <= prem_fix[W-1:0];
        div_zero <= zflag;
      end
    end
  end

  // R8: corrected remainder is below a non-zero divisor
  p_rem_below_div_r8: assert property (@(posedge clk) disable iff (rst)
    (fix_en && !zflag) |=> (rem_hi < dvs));

  // R5: zero divisor yields an all-ones quotient and the dividend back
  p_zero_ones_r5: assert property (@(posedge clk) disable iff (rst)
    (fix_en && zflag) |=> (div_zero && (quot_lo == {W{1'b1}})));
endmodule

// File: rtl/seq_udiv_nr.sv
module seq_udiv_nr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot_lo,
  output logic [W-1:0] rem_hi,
  output logic         div_zero
);
  logic load;
  logic step_en;
  logic fix_en;

  nrdiv_fsm #(.W(W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .load    (load),
    .step_en (step_en),
    .fix_en  (fix_en),
    .busy    (busy),
    .done    (done)
  );

  nrdiv_core #(.W(W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step_en  (step_en),
    .fix_en   (fix_en),
    .dividend (dividend),
    .divisor  (divisor),
    .quot_lo  (quot_lo),
    .rem_hi   (rem_hi),
    .div_zero (div_zero)
  );

  // R6: results move only together with the done pulse
  p_hold_results_r6: assert property (@(posedge clk) disable iff (rst)
    !$rose(done) |-> ($stable(quot_lo) && $stable(rem_hi) && $stable(div_zero)));
endmodule

// File: tb/seq_udiv_nr_tb.sv
module seq_udiv_nr_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;   // 200 MHz

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // 32-bit instance
  logic        st32 = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic        busy32, done32, dz32;
  logic [31:0] q32, r32;

  seq_udiv_nr #(.W(32)) u_dut (
    .clk(clk), .rst(rst), .start(st32), .dividend(a32), .divisor(b32),
    .busy(busy32), .done(done32), .quot_lo(q32), .rem_hi(r32), .div_zero(dz32)
  );

  // 4-bit instance
  logic       st4 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       busy4, done4, dz4;
  logic [3:0] q4, r4;

  seq_udiv_nr #(.W(4)) u_dut4 (
    .clk(clk), .rst(rst), .start(st4), .dividend(a4), .divisor(b4),
    .busy(busy4), .done(done4), .quot_lo(q4), .rem_hi(r4), .div_zero(dz4)
  );

  typedef struct { logic [31:0] q; logic [31:0] r; logic z; } exp_t;
  exp_t sb32[$];
  exp_t sb4[$];

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                 input logic [31:0] mask);
    exp_t e;
    if ((b & mask) == 0) begin
      e.q = mask; e.r = a & mask; e.z = 1'b1;
    end else begin
      e.q = (a & mask) / (b & mask); e.r = (a & mask) % (b & mask); e.z = 1'b0;
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitors: pop the scoreboard on each done pulse
  always @(negedge clk) begin
    if (!rst && done32) begin
      if (sb32.size() == 0) check(1'b0, "R4", "w32 unexpected done", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb32.pop_front();
        check(q32 == e.q, e.z ? "R5" : "R1", "w32 quotient", q32, e.q);
        check(r32 == e.r, e.z ? "R5" : "R1", "w32 remainder", r32, e.r);
        check(dz32 == e.z, "R5", "w32 div_zero", {31'd0, dz32}, {31'd0, e.z});
        if (!e.z) check(r32 < b32 || b32 == 0, "R8", "w32 rem below divisor", r32, b32);
      end
    end
    if (!rst && done4) begin
      if (sb4.size() == 0) check(1'b0, "R4", "w4 unexpected done", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb4.pop_front();
        check({28'd0, q4} == e.q, e.z ? "R5" : "R1", "w4 quotient", {28'd0, q4}, e.q);
        check({28'd0, r4} == e.r, e.z ? "R5" : "R8", "w4 remainder", {28'd0, r4}, e.r);
        check(dz4 == e.z, "R5", "w4 div_zero", {31'd0, dz4}, {31'd0, e.z});
      end
    end
  end

  // driver for the 32-bit instance; poke injects a start mid-run (R4)
  task automatic run32(input logic [31:0] a, input logic [31:0] b, input bit poke);
    int lat;
    logic [31:0] hq, hr;
    sb32.push_back(model(a, b, 32'hFFFF_FFFF));
    @(negedge clk);
    st32 = 1'b1; a32 = a; b32 = b;
    @(negedge clk);
    st32 = 1'b0;
    lat = 0;
    check(busy32 == 1'b1, "R3", "busy after start", {31'd0, busy32}, 32'd1);
    while (!done32 && lat < 100) begin
      if (poke && lat == 3) begin st32 = 1'b1; a32 = ~a; b32 = 32'd1; end
      if (poke && lat == 4) begin st32 = 1'b0; a32 = a;  b32 = b;     end
      @(negedge clk);
      lat++;
      if (!done32)
        check(busy32 == 1'b1, "R3", "busy during run", {31'd0, busy32}, 32'd1);
    end
    check(lat == 33, b == 0 ? "R5" : "R2", "w32 latency", lat, 32'd33);
    check(busy32 == 1'b0, "R3", "busy low with done", {31'd0, busy32}, 32'd0);
    hq = q32; hr = r32;
    @(negedge clk);
    check(done32 == 1'b0, "R2", "done one cycle", {31'd0, done32}, 32'd0);
    repeat (2) @(negedge clk);
    check(q32 == hq && r32 == hr, "R6", "results held", q32, hq);
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] b);
    int lat;
    sb4.push_back(model({28'd0, a}, {28'd0, b}, 32'h0000_000F));
    @(negedge clk);
    st4 = 1'b1; a4 = a; b4 = b;
    @(negedge clk);
    st4 = 1'b0;
    lat = 0;
    while (!done4 && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 5, "R2", "w4 latency", lat, 32'd5);
    @(negedge clk);
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  initial begin
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    // R7: reset state
    check(!busy32 && !done32 && q32 == 0 && r32 == 0 && !dz32, "R7",
          "w32 reset state", q32 | r32, 32'd0);
    check(!busy4 && !done4 && q4 == 0 && r4 == 0 && !dz4, "R7",
          "w4 reset state", {28'd0, q4 | r4}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy32 && !done32 && q32 == 0 && !dz32, "R7", "after reset",
          {31'd0, busy32}, 32'd0);

    run32(32'd26, 32'd5, 1'b0);                 // R1
    run32(32'd7, 32'd2, 1'b0);                  // R1
    run32(32'hFFFF_FFFF, 32'd1, 1'b0);          // R9
    run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);  // R9
    run32(32'd5, 32'd26, 1'b0);                 // R9 dividend below divisor
    run32(32'h8000_0000, 32'hFFFF_FFFF, 1'b0);  // R9
    run32(32'hFFFF_FFFF, 32'h8000_0000, 1'b0);  // R9, R8
    run32(32'd0, 32'd7, 1'b0);                  // R1
    run32(32'd1_000_000_007, 32'd3, 1'b0);      // R1
    run32(32'h1234_5678, 32'd0, 1'b0);          // R5
    run32(32'd100, 32'd7, 1'b1);                // R4 start during busy
    seed = 32'h2545_F491;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b;
      seed = xs(seed); a = seed;
      seed = xs(seed); b = seed >> (seed[4:0]);
      run32(a, b, 1'b0);
    end
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        run4(4'(x), 4'(y));                     // R1, R5, R8 exhaustive
    repeat (4) @(negedge clk);
    check(sb32.size() == 0 && sb4.size() == 0, "R2", "all results seen",
          sb32.size() + sb4.size(), 32'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule